// File: doc/BRIEF.md
# Chopper decay-mode controller

This block decides, cycle by cycle, which current mode one H-bridge winding uses inside each fixed chopping period: charge, slow decay or fast decay. An internal timer cuts every period into eight equal slots of `SLOT_CYCLES` system clocks each. The first slot is always spent charging. The last slot is always spent in fast decay. Between those two slots, the mode follows a comparator bit that reports whether the coil current is below its set-point.

The comparator arrives without timing, so it passes through a two-stage synchronizer before any decision uses it. There are two ways through a period:

- If the current is seen below the set-point while charging, charge continues until the current reaches the set-point. The winding then rests in slow decay, and a fast-decay tail fills the last slot.
- If the current is never seen below the set-point while charging, the winding switches to fast decay once the forced charge ends and stays there until the period closes.

The slot size sets the chopping frequency. For example, 125 clocks per slot at 100 MHz gives 100 kHz, inside the usual 50 to 200 kHz band. Pulling `enable` low turns the bridge off and restarts the period timer.

Top module: `chop_decay_ctrl`

## Requirements
- R1: While `rst` is high, `mode_o` is 2'b00 (off) and `period_start_o` is 0. Mode codes are 00 off, 01 charge, 10 slow decay and 11 fast decay.
- R2: A clock edge that sees `enable` low makes `mode_o` off and restarts the timer. The first edge that sees `enable` high again starts a new period.
- R3: A period lasts 8*SLOT_CYCLES clocks. `mode_o` is charge during the whole first slot of a period, whatever the comparator says.
- R4: `coil_below` takes effect two clock edges late (synchronizer). While charging after the first slot, charge continues as long as the synchronized bit stays high and has been high at some point in the period.
- R5: While charging after the first slot, if the synchronized bit has been high at some point in the period and is now low, the next mode is slow decay.
- R6: Slow decay holds until the last slot, then becomes fast decay.
- R7: While charging after the first slot, if the synchronized bit has not been high at any point since the period started, the next mode is fast decay.
- R8: If charge is still active when the last slot begins, the mode becomes fast decay.
- R9: Fast decay holds until the period ends, whatever the comparator does.
- R10: `period_start_o` is high for exactly the first clock of each period, which is the clock in which `mode_o` first shows charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Low forces the bridge off and restarts the period |
| coil_below | input | 1 | Asynchronous comparator: 1 when coil current is below the set-point |
| mode_o | output | 2 | Registered mode code: 00 off, 01 charge, 10 slow, 11 fast |
| period_start_o | output | 1 | Registered one-clock pulse at the start of each period |

## Verification
The case hardest to reach is a comparator that is high only inside the forced-charge slot and low after it. The bench must prove that the block remembers the earlier low-current event and goes to slow decay instead of fast decay. The stimulus holds the comparator high for only the first few clocks of a period and then drops it. Another period keeps it low through the forced slot and raises it later, to show that fast decay stays put. A mid-period disable followed by re-enable checks that the timer realigns.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int SLOT_BITS = 3;
  localparam int NUM_SLOTS = 1 << SLOT_BITS;

  typedef enum logic [1:0] {
    CM_OFF    = 2'b00,
    CM_CHARGE = 2'b01,
    CM_SLOW   = 2'b10,
    CM_FAST   = 2'b11
  } chop_mode_t;
endpackage

// File: rtl/chop_slot_timer.sv
module chop_slot_timer
  import chop_pkg::*;
#(
  parameter int SLOT_CYCLES = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic first_slot_o,
  output logic last_slot_o,
  output logic period_begin_o
);
  localparam int DIV_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(SLOT_CYCLES - 1);
  localparam logic [SLOT_BITS-1:0] LAST_SLOT = SLOT_BITS'(NUM_SLOTS - 1);

  logic [DIV_W-1:0]     div_q;
  logic [SLOT_BITS-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q  <= '0;
      slot_q <= '0;
    end else if (div_q == DIV_MAX) begin
      div_q  <= '0;
      slot_q <= slot_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign first_slot_o   = (slot_q == '0);
  assign last_slot_o    = (slot_q == LAST_SLOT);
  assign period_begin_o = (slot_q == '0) && (div_q == '0);

  // R10: the period wraps back to its first clock after the last slot
  p_period_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (run && slot_q == LAST_SLOT && div_q == DIV_MAX) |=> (slot_q == '0 && div_q == '0));

  // R2: a stopped timer sits at the period origin
  p_timer_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (slot_q == '0 && div_q == '0));
endmodule

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/chop_mode_fsm.sv
module chop_mode_fsm
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       below,
  input  logic       first_slot,
  input  logic       last_slot,
  input  logic       period_begin,
  output chop_mode_t mode_o,
  output logic       start_o
);
  chop_mode_t mode_q, mode_n;
  logic       seen_q, seen_n;

  always_comb begin
    mode_n = mode_q;
    seen_n = seen_q | below;
    if (!run) begin
      mode_n = CM_OFF;
      seen_n = 1'b0;
    end else if (period_begin) begin
      mode_n = CM_CHARGE;
      seen_n = below;
    end else begin
      case (mode_q)
        CM_CHARGE: begin
          if (last_slot)       mode_n = CM_FAST;
          else if (first_slot) mode_n = CM_CHARGE;
          else if (!seen_n)    mode_n = CM_FAST;
          else if (!below)     mode_n = CM_SLOW;
          else                 mode_n = CM_CHARGE;
        end
        CM_SLOW: begin
          if (last_slot) mode_n = CM_FAST;
        end
        CM_FAST: mode_n = CM_FAST;
        default: mode_n = CM_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= CM_OFF;
      seen_q  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      seen_q  <= seen_n;
      start_o <= run && period_begin;
    end
  end

  assign mode_o = mode_q;

  // R2: disable turns the bridge off on the next clock
  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (mode_q == CM_OFF));

  // R3: the first slot of every period charges
  p_forced_charge_r3: assert property (@(posedge clk) disable iff (rst)
    (run && first_slot) |=> (mode_q == CM_CHARGE));

  // R6: slow decay gives way to the fast tail in the last slot
  p_slow_to_fast_r6: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q == CM_SLOW && last_slot) |=> (mode_q == CM_FAST));

  // R9: fast decay is never left before the period ends
  p_fast_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q == CM_FAST && !first_slot) |=> (mode_q == CM_FAST));

  // R10: the start pulse coincides with a fresh charge
  p_start_charge_r10: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (mode_q == CM_CHARGE));
endmodule

// File: rtl/chop_decay_ctrl.sv
module chop_decay_ctrl
  import chop_pkg::*;
#(
  parameter int SLOT_CYCLES = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       coil_below,
  output logic [1:0] mode_o,
  output logic       period_start_o
);
  logic       below_s;
  logic       first_slot, last_slot, period_begin;
  chop_mode_t mode_w;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (coil_below),
    .q   (below_s)
  );

  chop_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk            (clk),
    .rst            (rst),
    .run            (enable),
    .first_slot_o   (first_slot),
    .last_slot_o    (last_slot),
    .period_begin_o (period_begin)
  );

  chop_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .run          (enable),
    .below        (below_s),
    .first_slot   (first_slot),
    .last_slot    (last_slot),
    .period_begin (period_begin),
    .mode_o       (mode_w),
    .start_o      (period_start_o)
  );

  assign mode_o = mode_w;
endmodule

// File: tb/sim_chop_decay_ctrl.sv
module sim_chop_decay_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 10;
  localparam int PER  = 8 * SLOT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic coil_below = 1'b0;
  logic [1:0] mode_o;
  logic period_start_o;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  chop_decay_ctrl #(.SLOT_CYCLES(SLOT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .coil_below(coil_below),
    .mode_o(mode_o), .period_start_o(period_start_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int    m_t = 0;
  bit    m_s1 = 0, m_s2 = 0, m_seen = 0;
  int    e_mode = 0;
  bit    e_start = 0;
  string e_tag = "R1";

  always @(posedge clk) begin
    bit b;
    int sl;
    started = 1;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_seen = 0; m_t = 0;
      e_mode = 0; e_start = 0; e_tag = "R1";
    end else begin
      b = m_s2;
      m_s2 = m_s1;
      m_s1 = coil_below;
      if (!enable) begin
        e_mode = 0; e_start = 0; m_seen = 0; m_t = 0; e_tag = "R2";
      end else begin
        sl = m_t / SLOT;
        e_start = (m_t == 0);
        if (m_t == 0) begin
          e_mode = 1; m_seen = b; e_tag = "R3";
        end else if (e_mode == 1) begin
          m_seen = m_seen | b;
          if (sl == 7)          begin e_mode = 3; e_tag = "R8"; end
          else if (sl == 0)     begin e_mode = 1; e_tag = "R3"; end
          else if (!m_seen)     begin e_mode = 3; e_tag = "R7"; end
          else if (!b)          begin e_mode = 2; e_tag = "R5"; end
          else                  begin e_mode = 1; e_tag = "R4"; end
        end else if (e_mode == 2) begin
          m_seen = m_seen | b;
          e_mode = (sl == 7) ? 3 : 2; e_tag = "R6";
        end else begin
          m_seen = m_seen | b;
          e_mode = 3; e_tag = "R9";
        end
        m_t = (m_t + 1) % PER;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (mode_o !== e_mode[1:0]) begin
        errors++;
        $display("FAIL %s mode actual %0d expected %0d at %0t", e_tag, mode_o, e_mode, $time);
      end
      checks++;
      if (period_start_o !== e_start) begin
        errors++;
        $display("FAIL %s period_start (R10) actual %0b expected %0b at %0t",
                 e_tag, period_start_o, e_start, $time);
      end
    end
  end

  task automatic hold(input bit en, input bit cmp, input int n);
    enable = en;
    coil_below = cmp;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state observed by the per-cycle compare
    rst = 1'b0;
    hold(0, 0, 3);                          // R2 idle off
    hold(1, 1, PER);                        // R8 charge never satisfied
    hold(1, 1, 35); hold(1, 0, PER - 35);   // R5 then R6 tail
    hold(1, 0, PER);                        // R7 never below
    hold(1, 0, 20); hold(1, 1, PER - 20);   // R9 fast ignores later low current
    hold(1, 1, 4);  hold(1, 0, PER - 4);    // R5 below only inside forced slot
    hold(1, 1, 30); hold(0, 1, 5);          // R2 disable mid period
    hold(1, 1, 40); hold(1, 0, PER - 40 + 5); // R3 restart aligned
    hold(1, 1, 2);  hold(1, 0, 1); hold(1, 1, PER - 3); // R4 short pulses
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule